// File: doc/BRIEF.md
# Double-Buffered Synchronous Character Transmitter

This block turns characters written by a host into an unbroken synchronous bit stream. It advances one bit each time the external bit strobe pulses. It has two storage stages: a holding register that the host writes, and a shift register that feeds the line. The host can therefore place the next character while the current one is still going out. When a character leaves the last stage, the character waiting in the holding register follows on the very next strobe, so no gap appears between characters.

When the holding register is empty and idle fill is enabled, the block sends the programmed sync pattern instead of data. A new character always starts only at a character boundary. Clear-to-send gates the start of every character. The block drives request-to-send itself. It raises a done flag at the moment a host character moves into the shift register, which tells the host that the holding register is free again. An interrupt request follows the done flag when the enable input allows it.

Top module: `sync_tx_dbuf`

## Requirements
- R1: After reset, `txd_o` is 1 (marking), and `rts_o`, `done_o` and `irq_o` are all 0.
- R2: Character length is set at each character start. `len_sel_i` = 0 gives 6 bits, 1 gives 7 bits, and 2 or 3 gives 8 bits. `ext_len_i` = 1 adds 4 bits, which gives 10, 11 or 12 bits. Data bits above the length are never sent.
- R3: Bits go out least significant first, one bit per strobe. `txd_o` changes only in the cycle after a strobe.
- R4: `done_o` sets in the same strobe cycle in which a host character leaves the holding register and its bit 0 appears on `txd_o`.
- R5: A character that is held while another is shifting follows the last bit of that character on the next strobe, with no gap. A second write while the holding register is full replaces the held character.
- R6: `rts_o` is 1 whenever the holding register is full, or `idle_en_i` is 1, or a character bit is on the line.
- R7: With the holding register empty and idle fill off, the strobe after the last bit drives `txd_o` to 1 and drops `rts_o`.
- R8: With idle fill on and the holding register empty, the sync pattern is sent repeatedly. A host character waits for the current sync pattern to finish and then goes before the next one. Sync starts do not set `done_o`.
- R9: A character starts only while `cts_i` is 1. Otherwise the line stays at marking and the character waits. A character that has already started finishes even if `cts_i` drops.
- R10: `irq_o` is 1 exactly when `done_o` and `done_ie_i` are both 1.
- R11: A host write clears `done_o` in the cycle after the write.
- R12: If a write and a character start fall in the same cycle, the old held character goes to the line, the new one is held, and `done_o` ends up 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | MAX_W | Character written by the host |
| sync_pat_i | input | MAX_W | Sync pattern used for idle fill |
| len_sel_i | input | 2 | Character length code |
| ext_len_i | input | 1 | Extended length (adds 4 bits) |
| idle_en_i | input | 1 | Idle fill with the sync pattern |
| cts_i | input | 1 | Clear-to-send from the modem |
| bit_stb_i | input | 1 | Transmit bit strobe, one cycle per bit |
| done_ie_i | input | 1 | Interrupt enable for the done flag |
| txd_o | output | 1 | Serial data out |
| rts_o | output | 1 | Request-to-send |
| done_o | output | 1 | Transmit done flag |
| irq_o | output | 1 | Transmit interrupt request |

## Verification
The main collision is a host write landing in the same cycle as the strobe that moves the held character into the shift register. In that one cycle the holding register is both emptied and refilled, and the done flag is both set and cleared. The bench drives the write and the strobe on the same clock edge, just after the last bit of a running character. It then checks three things: the old character's bits appear with no gap, the newly written character follows right after them, and `done_o` reads 0 until the new character itself starts. A write that arrives in the middle of an idle sync pattern is also checked, to confirm that the sync pattern is never cut short.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_HOLD, SRC_SYNC} src_e;

  // length code: 0->base, 1->base+1, 2/3->base+2
  function automatic int unsigned len_of(input logic [1:0] sel, input logic ext,
                                         input int unsigned base, input int unsigned ext_add);
    int unsigned l;
    l = base + ((sel > 2'd2) ? 2 : int'(sel));
    if (ext) l = l + ext_add;
    return l;
  endfunction
endpackage

// File: rtl/sctx_hold.sv
module sctx_hold #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         take_i,
  output logic [W-1:0] data_o,
  output logic         valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (wr_en_i) begin
      data_o  <= wr_data_i;
      valid_o <= 1'b1;
    end else if (take_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sctx_shift.sv
module sctx_shift #(
  parameter int unsigned W     = 12,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             ld_i,
  input  logic [W-1:0]     ld_data_i,
  input  logic [CNT_W-1:0] ld_len_i,
  output logic             txd_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             busy_o
);
  logic [W-1:0] sh_q;
  logic [W-1:0] mask;

  // keep only the bits inside the selected length
  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (CNT_W'(i) < ld_len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      cnt_o  <= '0;
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
    end else if (stb_i) begin
      if (ld_i) begin
        txd_o  <= ld_data_i[0];
        sh_q   <= (ld_data_i & mask) >> 1;
        cnt_o  <= ld_len_i - CNT_W'(1);
        busy_o <= 1'b1;
      end else if (cnt_o != '0) begin
        txd_o  <= sh_q[0];
        sh_q   <= sh_q >> 1;
        cnt_o  <= cnt_o - CNT_W'(1);
      end else begin
        txd_o  <= 1'b1;
        busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sctx_ctrl.sv
module sctx_ctrl
  import sctx_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned BASE_LEN = 6,
  parameter int unsigned EXT_ADD  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             busy_i,
  input  logic             hold_valid_i,
  input  logic             wr_en_i,
  input  logic             cts_i,
  input  logic             idle_en_i,
  input  logic [1:0]       len_sel_i,
  input  logic             ext_len_i,
  input  logic             done_ie_i,
  output src_e             src_o,
  output logic [CNT_W-1:0] len_o,
  output logic             done_o,
  output logic             irq_o,
  output logic             rts_o
);
  logic at_boundary;

  assign at_boundary = stb_i && (cnt_i == '0) && cts_i;

  always_comb begin
    src_o = SRC_NONE;
    if (at_boundary) begin
      if (hold_valid_i)   src_o = SRC_HOLD;
      else if (idle_en_i) src_o = SRC_SYNC;
    end
  end

  assign len_o = CNT_W'(len_of(len_sel_i, ext_len_i, BASE_LEN, EXT_ADD));

  // host write wins over a simultaneous start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                done_o <= 1'b0;
    else if (wr_en_i)           done_o <= 1'b0;
    else if (src_o == SRC_HOLD) done_o <= 1'b1;
  end

  assign irq_o = done_o & done_ie_i;
  assign rts_o = hold_valid_i | idle_en_i | busy_i;
endmodule

// File: rtl/sync_tx_dbuf.sv
module sync_tx_dbuf
  import sctx_pkg::*;
#(
  parameter int unsigned MAX_W    = 12,
  parameter int unsigned BASE_LEN = 6,
  parameter int unsigned EXT_ADD  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [MAX_W-1:0] wr_data_i,
  input  logic [MAX_W-1:0] sync_pat_i,
  input  logic [1:0]       len_sel_i,
  input  logic             ext_len_i,
  input  logic             idle_en_i,
  input  logic             cts_i,
  input  logic             bit_stb_i,
  input  logic             done_ie_i,
  output logic             txd_o,
  output logic             rts_o,
  output logic             done_o,
  output logic             irq_o
);
  localparam int unsigned CNT_W = $clog2(MAX_W + 1);

  src_e             src;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic             hold_valid;
  logic [MAX_W-1:0] hold_data;
  logic [MAX_W-1:0] ld_data;
  logic             take;
  logic             ld;

  assign take    = (src == SRC_HOLD);
  assign ld      = (src != SRC_NONE);
  assign ld_data = take ? hold_data : sync_pat_i;

  sctx_hold #(.W(MAX_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .data_o    (hold_data),
    .valid_o   (hold_valid)
  );

  sctx_shift #(.W(MAX_W), .CNT_W(CNT_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (bit_stb_i),
    .ld_i      (ld),
    .ld_data_i (ld_data),
    .ld_len_i  (len),
    .txd_o     (txd_o),
    .cnt_o     (cnt),
    .busy_o    (busy)
  );

  sctx_ctrl #(.CNT_W(CNT_W), .BASE_LEN(BASE_LEN), .EXT_ADD(EXT_ADD)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stb_i        (bit_stb_i),
    .cnt_i        (cnt),
    .busy_i       (busy),
    .hold_valid_i (hold_valid),
    .wr_en_i      (wr_en_i),
    .cts_i        (cts_i),
    .idle_en_i    (idle_en_i),
    .len_sel_i    (len_sel_i),
    .ext_len_i    (ext_len_i),
    .done_ie_i    (done_ie_i),
    .src_o        (src),
    .len_o        (len),
    .done_o       (done_o),
    .irq_o        (irq_o),
    .rts_o        (rts_o)
  );
endmodule

// File: rtl/sctx_chk.sv
module sctx_chk #(
  parameter int unsigned MAX_W = 12,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             bit_stb_i,
  input logic             cts_i,
  input logic             idle_en_i,
  input logic             txd_o,
  input logic             rts_o,
  input logic             done_o,
  input logic             take,
  input logic             hold_valid,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  assert_txd_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_stb_i |=> $stable(txd_o));

  assert_done_on_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !wr_en_i) |=> done_o);

  assert_rts_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rts_o);

  assert_mark_when_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && cnt == '0 && !hold_valid && !idle_en_i) |=> (txd_o && !busy));

  assert_no_start_without_cts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0 && !cts_i) |=> cnt == '0);

  assert_write_clears_done_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !done_o);

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CNT_W'(MAX_W));
endmodule

bind sync_tx_dbuf sctx_chk #(.MAX_W(MAX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .bit_stb_i  (bit_stb_i),
  .cts_i      (cts_i),
  .idle_en_i  (idle_en_i),
  .txd_o      (txd_o),
  .rts_o      (rts_o),
  .done_o     (done_o),
  .take       (take),
  .hold_valid (hold_valid),
  .busy       (busy),
  .cnt        (cnt)
);

// File: tb/sync_tx_dbuf_test.sv
module sync_tx_dbuf_test;
  localparam int unsigned W = 12;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] sync_pat = '0;
  logic [1:0]   len_sel = 2'd2;
  logic         ext_len = 1'b0;
  logic         idle_en = 1'b0;
  logic         cts = 1'b1;
  logic         bit_stb = 1'b0;
  logic         done_ie = 1'b0;
  logic         txd, rts, done, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_tx_dbuf uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .sync_pat_i(sync_pat), .len_sel_i(len_sel), .ext_len_i(ext_len),
    .idle_en_i(idle_en), .cts_i(cts), .bit_stb_i(bit_stb), .done_ie_i(done_ie),
    .txd_o(txd), .rts_o(rts), .done_o(done), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    wr_en = 0; bit_stb = 0; idle_en = 0; cts = 1; done_ie = 0;
    len_sel = 2'd2; ext_len = 0;
    @(negedge clk); rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic strobe(output logic b);
    @(negedge clk); bit_stb = 1;
    @(negedge clk); bit_stb = 0; b = txd;
    repeat (2) @(negedge clk);
  endtask

  // strobes n times and compares each bit with d, LSB first
  task automatic expect_bits(input string req, input logic [W-1:0] d, input int n, input int skip);
    logic b;
    for (int i = skip; i < n; i++) begin
      strobe(b);
      check(req, b, d[i]);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 txd", txd, 1);
    check("R1 rts", rts, 0);
    check("R1 done", done, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_single();
    logic b;
    do_reset();
    write(12'h0A5);
    check("R6 rts held", rts, 1);
    check("R11 done after write", done, 0);
    strobe(b);
    check("R3 bit0", b, 1);
    check("R4 done on start", done, 1);
    expect_bits("R3 lsb first", 12'h0A5, 8, 1);
    check("R6 rts last bit", rts, 1);
    strobe(b);
    check("R7 mark", b, 1);
    check("R7 rts drop", rts, 0);
    repeat (3) @(negedge clk);
    check("R3 stable", txd, 1);
  endtask

  task automatic t_back_to_back();
    logic b;
    do_reset();
    write(12'h0C3);
    strobe(b);
    check("R5 A bit0", b, 1);
    write(12'h05A);
    check("R11 clear", done, 0);
    expect_bits("R5 A rest", 12'h0C3, 8, 1);
    check("R4 no done yet", done, 0);
    expect_bits("R5 B follows", 12'h05A, 8, 0);
    check("R4 done B", done, 1);
    strobe(b);
    check("R7 mark after B", b, 1);
  endtask

  task automatic t_irq();
    logic b;
    do_reset();
    write(12'h001);
    strobe(b);
    check("R10 masked", irq, 0);
    done_ie = 1; @(negedge clk);
    check("R10 enabled", irq, 1);
    write(12'h002);
    check("R10 cleared by write", irq, 0);
    check("R11 write clears", done, 0);
  endtask

  task automatic t_idle();
    do_reset();
    sync_pat = 12'h016;
    idle_en = 1; @(negedge clk);
    check("R6 rts idle", rts, 1);
    expect_bits("R8 sync1", 12'h016, 8, 0);
    expect_bits("R8 sync2", 12'h016, 8, 0);
    check("R8 no done", done, 0);
    expect_bits("R8 sync3 head", 12'h016, 4, 0);
    write(12'h03C);
    expect_bits("R8 sync3 tail", 12'h016, 8, 4);
    expect_bits("R8 data", 12'h03C, 8, 0);
    check("R8 done data", done, 1);
    expect_bits("R8 sync resume", 12'h016, 8, 0);
  endtask

  task automatic t_cts();
    logic b;
    do_reset();
    cts = 0;
    write(12'h055);
    write(12'h00F);
    for (int i = 0; i < 4; i++) begin
      strobe(b);
      check("R9 held mark", b, 1);
    end
    check("R9 no done", done, 0);
    check("R6 rts waiting", rts, 1);
    cts = 1;
    expect_bits("R5 overwrite head", 12'h00F, 3, 0);
    cts = 0;
    expect_bits("R9 finish", 12'h00F, 8, 3);
    strobe(b);
    check("R9 end mark", b, 1);
  endtask

  task automatic t_lengths();
    logic b;
    do_reset();
    len_sel = 2'd0;
    write(12'hFED);
    expect_bits("R2 six", 12'hFED, 6, 0);
    strobe(b);
    check("R2 six end", b, 1);
    len_sel = 2'd1; ext_len = 1;
    write(12'hFA5);
    expect_bits("R2 eleven", 12'hFA5, 11, 0);
    strobe(b);
    check("R2 eleven end", b, 1);
    len_sel = 2'd3;
    write(12'hA5C);
    expect_bits("R2 twelve", 12'hA5C, 12, 0);
    strobe(b);
    check("R2 twelve end", b, 1);
    len_sel = 2'd1; ext_len = 0;
    write(12'hFFF);
    expect_bits("R2 seven", 12'hFFF, 7, 0);
    strobe(b);
    check("R2 seven end", b, 1);
  endtask

  task automatic t_collision();
    logic b;
    do_reset();
    len_sel = 2'd0;
    write(12'h015);
    strobe(b);
    write(12'h02A);
    expect_bits("R12 A rest", 12'h015, 6, 1);
    @(negedge clk); bit_stb = 1; wr_en = 1; wr_data = 12'h033;
    @(negedge clk); bit_stb = 0; wr_en = 0;
    check("R12 B bit0", txd, 0);
    check("R12 done clear", done, 0);
    check("R12 rts", rts, 1);
    repeat (2) @(negedge clk);
    expect_bits("R12 B rest", 12'h02A, 6, 1);
    check("R12 still clear", done, 0);
    expect_bits("R12 C follows", 12'h033, 6, 0);
    check("R12 done C", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single();
    t_back_to_back();
    t_irq();
    t_idle();
    t_cts();
    t_lengths();
    t_collision();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule